// File: doc/BRIEF.md
# Regulator Over-Drive Handshake Controller

This block runs the two-step handshake that moves the core voltage regulator from its normal output level to a raised over-drive level and back. Software first sets a boost-enable bit. The controller then asks the regulator to prepare, and it reports a boost-ready flag once the regulator says it has settled. Software then sets a boost-switch bit. The controller asks the regulator for the raised level and holds the system clock stalled until the regulator settles there. After that it raises a switch-ready flag and lets the clock run again.

The return path has two forms. Clearing only the switch bit brings the regulator back to normal, keeps boosting enabled and leaves the block ready to switch up again. Clearing the enable bit drops both bits and takes the regulator back to its initial level. Both return paths stall the clock until the regulator has settled.

Software writes are accepted only while the system clock comes from an oscillator and not from the PLL, and only while the clock is not stalled. A Stop-mode exit pulse clears all state at once. When the supply is in its lowest range, or the regulator is bypassed, boosting is unavailable. A settle watchdog raises an error flag if the regulator does not answer a request in time.

Top module: `vreg_boost_ctrl`

## Requirements
- R1: An accepted write with `wr_boost_en`=1 sets `boost_en_q` and `reg_prep_req` on the next cycle. `boost_ready` rises only after `reg_settled` is seen high. `reg_settled` is ignored in the first cycle after any change of the request to the regulator, and the regulator must drop it within that cycle.
- R2: `wr_boost_sw`=1 takes effect only when `boost_ready` is already 1 at the time of the write. In any other case `boost_sw_q` stays 0 and `clk_stall` stays 0.
- R3: After an accepted switch-up, `clk_stall`=1, `boost_sw_q`=1 and `reg_boost_sel`=1. When the regulator settles, `clk_stall` falls and `switch_ready` rises in the same cycle.
- R4: A write (`wr_en`=1) while `sysclk_is_pll`=1 has no effect on any output.
- R5: An accepted write with `wr_boost_en`=0 while boosted clears `boost_en_q` and `boost_sw_q` at once. It then holds `clk_stall`=1 with `reg_boost_sel`=0 until the regulator settles. After that, `switch_ready`, `boost_ready` and `reg_prep_req` are all 0.
- R6: An accepted write with enable=1 and switch=0 while boosted sets `clk_stall`=1 and `reg_boost_sel`=0. `switch_ready` stays 1 until the regulator settles and then falls. `boost_en_q` and `boost_ready` stay 1 throughout.
- R7: A `stop_exit` pulse clears `boost_en_q`, `boost_sw_q`, `boost_ready`, `switch_ready`, `clk_stall`, `reg_boost_sel` and `settle_err` on the next cycle, from any state.
- R8: While `supply_low`=1 or `reg_bypass`=1, `boost_ready` never sets, `reg_prep_req` stays 0, and the settle watchdog does not run.
- R9: If the regulator stays unsettled for more than `TIMEOUT_CYC` cycles of a wait, `settle_err` rises and stays high. It clears on the next accepted write or on a `stop_exit` pulse.
- R10: Writes presented while `clk_stall`=1 are ignored.
- R11: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe for the two control bits |
| wr_boost_en | input | 1 | Written value of the boost-enable bit |
| wr_boost_sw | input | 1 | Written value of the boost-switch bit |
| sysclk_is_pll | input | 1 | 1 when the PLL drives the system clock |
| stop_exit | input | 1 | One-cycle pulse on leaving Stop mode |
| supply_low | input | 1 | Supply is in its lowest range |
| reg_bypass | input | 1 | Regulator is bypassed |
| reg_settled | input | 1 | Regulator has settled at the requested configuration |
| boost_en_q | output | 1 | Current boost-enable bit |
| boost_sw_q | output | 1 | Current boost-switch bit |
| boost_ready | output | 1 | Regulator prepared for over-drive |
| switch_ready | output | 1 | Regulator running at the over-drive level |
| clk_stall | output | 1 | Stall the system clock |
| reg_prep_req | output | 1 | Preparation request to the regulator |
| reg_boost_sel | output | 1 | Request for the over-drive output level |
| settle_err | output | 1 | Settle watchdog expired |

## Verification
A wrong sequencer state shows up first on `clk_stall` and on the two ready flags, on the cycle after the write or settle event that caused it. A stall that never ends, or a ready flag that sets without a settle, can be seen within one regulator latency. A watchdog counter that runs wrongly shows only after roughly `TIMEOUT_CYC` cycles, on `settle_err`. For that reason the bench samples it both before and after the limit. Refused writes are checked by reading back the control bits and flags on the cycle that follows the write.

// File: rtl/vrb_pkg.sv
package vrb_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,  // boosting disabled, normal level
        ST_PREP  = 3'd1,  // enabled, waiting for regulator preparation
        ST_RDY   = 3'd2,  // prepared, normal level
        ST_UP    = 3'd3,  // stalled, moving to over-drive level
        ST_BOOST = 3'd4,  // running at over-drive level
        ST_DOWN  = 3'd5,  // stalled, back to normal, enable kept
        ST_DROP  = 3'd6   // stalled, back to initial level, enable cleared
    } vrb_state_e;

    typedef struct packed {
        logic valid;
        logic en;
        logic sw;
    } vrb_cmd_t;

    function automatic logic st_stalls(vrb_state_e s);
        return (s == ST_UP) || (s == ST_DOWN) || (s == ST_DROP);
    endfunction

    function automatic logic st_ready(vrb_state_e s);
        return (s == ST_RDY) || (s == ST_UP) || (s == ST_BOOST) || (s == ST_DOWN);
    endfunction

    function automatic logic st_enabled(vrb_state_e s);
        return (s != ST_OFF) && (s != ST_DROP);
    endfunction

endpackage

// File: rtl/vrb_wr_gate.sv
module vrb_wr_gate
    import vrb_pkg::*;
(
    input  logic     wr_en,
    input  logic     wr_boost_en,
    input  logic     wr_boost_sw,
    input  logic     sysclk_is_pll,
    input  logic     stalled,
    output vrb_cmd_t cmd
);
    always_comb begin
        cmd.valid = wr_en && !sysclk_is_pll && !stalled;
        cmd.en    = wr_boost_en;
        cmd.sw    = wr_boost_sw;
    end
endmodule

// File: rtl/vrb_settle_timer.sv
module vrb_settle_timer #(
    parameter int unsigned TIMEOUT_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic waiting,
    input  logic clr,
    output logic first_cyc,
    output logic err
);
    localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

    logic [CW-1:0] cnt;
    logic          at_limit;

    assign at_limit  = (cnt == LIMIT);
    assign first_cyc = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (waiting && !at_limit) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            err <= 1'b0;
        end else if (waiting && at_limit) begin
            err <= 1'b1;
        end
    end

    // R9
    err_needs_wait_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> $past(waiting));

    // R9
    err_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !err);
endmodule

// File: rtl/vrb_seq_fsm.sv
module vrb_seq_fsm
    import vrb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  vrb_cmd_t cmd,
    input  logic     stop_exit,
    input  logic     avail,
    input  logic     reg_settled,
    input  logic     first_cyc,
    output logic     phase_start,
    output logic     waiting,
    output logic     boost_en_q,
    output logic     boost_sw_q,
    output logic     boost_ready,
    output logic     switch_ready,
    output logic     clk_stall,
    output logic     reg_prep_req,
    output logic     reg_boost_sel
);
    vrb_state_e state, nxt;
    logic       done;

    assign done = reg_settled && !first_cyc;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:   if (cmd.valid && cmd.en) nxt = ST_PREP;
            ST_PREP:  if (cmd.valid && !cmd.en) nxt = ST_OFF;
                      else if (avail && done) nxt = ST_RDY;
            ST_RDY:   if (cmd.valid && !cmd.en) nxt = ST_OFF;
                      else if (cmd.valid && cmd.sw) nxt = ST_UP;
            ST_UP:    if (done) nxt = ST_BOOST;
            ST_BOOST: if (cmd.valid && !cmd.en) nxt = ST_DROP;
                      else if (cmd.valid && !cmd.sw) nxt = ST_DOWN;
            ST_DOWN:  if (done) nxt = ST_RDY;
            ST_DROP:  if (done) nxt = ST_OFF;
            default:  nxt = ST_OFF;
        endcase
        if (stop_exit) nxt = ST_OFF;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_OFF;
        else     state <= nxt;
    end

    assign phase_start   = (nxt != state);
    assign clk_stall     = st_stalls(state);
    assign waiting       = clk_stall || ((state == ST_PREP) && avail);
    assign boost_en_q    = st_enabled(state);
    assign boost_sw_q    = (state == ST_UP) || (state == ST_BOOST);
    assign boost_ready   = st_ready(state);
    assign switch_ready  = (state == ST_BOOST) || (state == ST_DOWN) || (state == ST_DROP);
    assign reg_prep_req  = (state != ST_OFF) && avail;
    assign reg_boost_sel = boost_sw_q;

    // R2
    sw_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(boost_sw_q) |-> $past(boost_ready));

    // R4
    pll_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cmd.valid && !stop_exit) |=> $stable(boost_en_q));

    // R5
    drop_clears_sw_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(boost_en_q) |-> !boost_sw_q);

    // R7
    stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
        stop_exit |=> (!boost_en_q && !boost_sw_q && !clk_stall && !switch_ready));

    // R8
    unavail_chk: assert property (@(posedge clk) disable iff (rst)
        (!avail && !boost_ready) |=> !boost_ready);
endmodule

// File: rtl/vreg_boost_ctrl.sv
module vreg_boost_ctrl
    import vrb_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_boost_en,
    input  logic wr_boost_sw,
    input  logic sysclk_is_pll,
    input  logic stop_exit,
    input  logic supply_low,
    input  logic reg_bypass,
    input  logic reg_settled,
    output logic boost_en_q,
    output logic boost_sw_q,
    output logic boost_ready,
    output logic switch_ready,
    output logic clk_stall,
    output logic reg_prep_req,
    output logic reg_boost_sel,
    output logic settle_err
);
    vrb_cmd_t cmd;
    logic     phase_start, waiting, first_cyc, avail;

    assign avail = !supply_low && !reg_bypass;

    vrb_wr_gate u_gate (
        .wr_en         (wr_en),
        .wr_boost_en   (wr_boost_en),
        .wr_boost_sw   (wr_boost_sw),
        .sysclk_is_pll (sysclk_is_pll),
        .stalled       (clk_stall),
        .cmd           (cmd)
    );

    vrb_seq_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .cmd           (cmd),
        .stop_exit     (stop_exit),
        .avail         (avail),
        .reg_settled   (reg_settled),
        .first_cyc     (first_cyc),
        .phase_start   (phase_start),
        .waiting       (waiting),
        .boost_en_q    (boost_en_q),
        .boost_sw_q    (boost_sw_q),
        .boost_ready   (boost_ready),
        .switch_ready  (switch_ready),
        .clk_stall     (clk_stall),
        .reg_prep_req  (reg_prep_req),
        .reg_boost_sel (reg_boost_sel)
    );

    vrb_settle_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .restart   (phase_start),
        .waiting   (waiting),
        .clr       (cmd.valid || stop_exit),
        .first_cyc (first_cyc),
        .err       (settle_err)
    );

    // R10
    stall_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_stall && !stop_exit && !$past(stop_exit)) |=> $stable(boost_en_q));
endmodule

// File: tb/vreg_boost_ctrl_test.sv
`timescale 1ns/1ps
module vreg_boost_ctrl_test;
    localparam int TMO = 40;
    localparam int LAT = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 0, wr_boost_en = 0, wr_boost_sw = 0;
    logic sysclk_is_pll = 0, stop_exit = 0, supply_low = 0, reg_bypass = 0;
    logic reg_settled;
    logic boost_en_q, boost_sw_q, boost_ready, switch_ready;
    logic clk_stall, reg_prep_req, reg_boost_sel, settle_err;
    logic hang = 0;
    logic done = 0;
    int   checks = 0;
    int   errors = 0;

    always #2.5 clk = ~clk;

    vreg_boost_ctrl #(.TIMEOUT_CYC(TMO)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_boost_en(wr_boost_en),
        .wr_boost_sw(wr_boost_sw), .sysclk_is_pll(sysclk_is_pll),
        .stop_exit(stop_exit), .supply_low(supply_low), .reg_bypass(reg_bypass),
        .reg_settled(reg_settled), .boost_en_q(boost_en_q), .boost_sw_q(boost_sw_q),
        .boost_ready(boost_ready), .switch_ready(switch_ready), .clk_stall(clk_stall),
        .reg_prep_req(reg_prep_req), .reg_boost_sel(reg_boost_sel),
        .settle_err(settle_err)
    );

    // regulator model: drops settled on any request change, settles after LAT cycles
    logic [1:0] tgt_q;
    int         lat_cnt;
    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q <= 2'b00; lat_cnt <= 0; reg_settled <= 1'b0;
        end else if ({reg_prep_req, reg_boost_sel} != tgt_q) begin
            tgt_q <= {reg_prep_req, reg_boost_sel}; lat_cnt <= 0; reg_settled <= 1'b0;
        end else begin
            if (lat_cnt < LAT) lat_cnt <= lat_cnt + 1;
            reg_settled <= !hang && (lat_cnt >= LAT);
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_bits(input logic en, input logic sw);
        @(negedge clk);
        wr_en = 1; wr_boost_en = en; wr_boost_sw = sw;
        @(negedge clk);
        wr_en = 0; wr_boost_en = 0; wr_boost_sw = 0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop_exit = 1;
        @(negedge clk); stop_exit = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 30 && !boost_ready; i++) @(negedge clk);
    endtask

    task automatic wait_unstall();
        for (int i = 0; i < 30 && clk_stall; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R11 en", boost_en_q, 0);   chk("R11 sw", boost_sw_q, 0);
        chk("R11 rdy", boost_ready, 0); chk("R11 swrdy", switch_ready, 0);
        chk("R11 stall", clk_stall, 0); chk("R11 prep", reg_prep_req, 0);
        chk("R11 sel", reg_boost_sel, 0); chk("R11 err", settle_err, 0);
    endtask

    task automatic t_switch_gate();
        write_bits(0, 1);
        chk("R2 sw from off", boost_sw_q, 0); chk("R2 stall from off", clk_stall, 0);
        write_bits(1, 1);
        chk("R2 sw with enable", boost_sw_q, 0);
        chk("R1 en set", boost_en_q, 1); chk("R1 prep req", reg_prep_req, 1);
        chk("R1 not ready yet", boost_ready, 0);
        write_bits(1, 1);
        chk("R2 sw before ready", boost_sw_q, 0); chk("R2 no stall", clk_stall, 0);
        wait_ready();
        chk("R1 ready after settle", boost_ready, 1);
        chk("R2 sw still off", boost_sw_q, 0);
    endtask

    task automatic t_switch_up();
        write_bits(1, 1);
        chk("R3 stall", clk_stall, 1); chk("R3 sw bit", boost_sw_q, 1);
        chk("R3 sel", reg_boost_sel, 1); chk("R3 swrdy low", switch_ready, 0);
        wait_unstall();
        chk("R3 unstalled", clk_stall, 0); chk("R3 swrdy", switch_ready, 1);
    endtask

    task automatic t_pll_refuse();
        sysclk_is_pll = 1;
        write_bits(0, 0);
        idle(2);
        chk("R4 en kept", boost_en_q, 1); chk("R4 sw kept", boost_sw_q, 1);
        chk("R4 swrdy kept", switch_ready, 1); chk("R4 no stall", clk_stall, 0);
        sysclk_is_pll = 0;
    endtask

    task automatic t_switch_down();
        write_bits(1, 0);
        chk("R6 stall", clk_stall, 1); chk("R6 sel low", reg_boost_sel, 0);
        chk("R6 swrdy held", switch_ready, 1);
        write_bits(0, 0);
        chk("R10 en kept in stall", boost_en_q, 1);
        wait_unstall();
        chk("R6 swrdy fell", switch_ready, 0); chk("R6 en kept", boost_en_q, 1);
        chk("R6 ready kept", boost_ready, 1); chk("R6 sw low", boost_sw_q, 0);
    endtask

    task automatic t_drop();
        write_bits(1, 1); wait_unstall();
        chk("R3 boosted again", switch_ready, 1);
        write_bits(0, 0);
        chk("R5 en cleared", boost_en_q, 0); chk("R5 sw cleared", boost_sw_q, 0);
        chk("R5 stall", clk_stall, 1); chk("R5 sel low", reg_boost_sel, 0);
        wait_unstall();
        chk("R5 swrdy", switch_ready, 0); chk("R5 ready", boost_ready, 0);
        chk("R5 prep", reg_prep_req, 0); chk("R5 unstalled", clk_stall, 0);
    endtask

    task automatic t_stop();
        write_bits(1, 0); wait_ready();
        write_bits(1, 1); wait_unstall();
        pulse_stop();
        chk("R7 en", boost_en_q, 0); chk("R7 sw", boost_sw_q, 0);
        chk("R7 swrdy", switch_ready, 0); chk("R7 ready", boost_ready, 0);
        chk("R7 sel", reg_boost_sel, 0);
        write_bits(1, 0); wait_ready();
        write_bits(1, 1);
        chk("R7 stalled before stop", clk_stall, 1);
        pulse_stop();
        chk("R7 stall cleared", clk_stall, 0); chk("R7 en in stall", boost_en_q, 0);
    endtask

    task automatic t_unavail();
        supply_low = 1;
        write_bits(1, 0); idle(60);
        chk("R8 low ready", boost_ready, 0); chk("R8 low prep", reg_prep_req, 0);
        chk("R8 low err", settle_err, 0);
        write_bits(0, 0); supply_low = 0;
        reg_bypass = 1;
        write_bits(1, 0); idle(20);
        chk("R8 bypass ready", boost_ready, 0);
        write_bits(0, 0); reg_bypass = 0;
    endtask

    task automatic t_timeout();
        hang = 1;
        write_bits(1, 0); idle(30);
        chk("R9 err before limit", settle_err, 0);
        idle(20);
        chk("R9 err after limit", settle_err, 1); chk("R9 no ready", boost_ready, 0);
        write_bits(0, 0);
        chk("R9 err cleared by write", settle_err, 0);
        hang = 0;
        idle(LAT + 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_switch_gate();
        t_switch_up();
        t_pll_refuse();
        t_switch_down();
        t_drop();
        t_stop();
        t_unavail();
        t_timeout();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule